// File: doc/BRIEF.md
# Banked Effective Address Generator

This block forms the 24-bit effective address for data accesses of a small microcontroller core. It keeps two base registers: an 8-bit bank register that supplies the top byte of absolute-family addresses, and a 16-bit page-base register that marks the lowest byte of a 256-byte direct window. Each register has its own load strobe and clears on reset.

Each cycle the core presents an addressing-mode code, an 8-bit direct offset, a 16-bit absolute operand and two 16-bit index values. The block returns the address combinationally from the current register contents. It also raises a flag when direct-window address generation needs one more cycle. The direct window may start anywhere in bank 0. A window whose base is near the top of bank 0 carries into bank 1 and does not wrap.

Top module: `bank_addr_gen`

## Requirements
- R1: While reset is asserted and after its release, the bank register reads 0x00 and the page-base register reads 0x0000. Both values are observable through the absolute and direct modes.
- R2: A bank load changes the bank byte at the next rising clock edge and not before. With the bank strobe low, the bank byte holds its value whatever is on the bank data input.
- R3: A page-base load changes the page base at the next rising clock edge and not before. With the page strobe low, the page base holds its value.
- R4: Mode code 0 (direct) gives address = page base + offset as a 24-bit sum starting from bank 0. For a base of 0xFF01 or above the sum carries into bit 16: 0xFF01 + 0xFF = 0x010000. No address in this mode exceeds 0x0100FE.
- R5: Mode codes 1 (direct indexed by X) and 2 (direct indexed by Y) give address = page base + offset + the selected index, as a 24-bit sum from bank 0.
- R6: Mode code 3 (absolute) gives address = {bank, operand}.
- R7: Mode codes 4 (absolute indexed by X) and 5 (absolute indexed by Y) give address = {bank, operand} + the zero-extended index. The carry spills into the bank byte, and the sum wraps at 24 bits.
- R8: In mode codes 0 to 2 the extra-cycle flag is high exactly when the low byte of the page base is nonzero. In mode codes 3 to 5 it is low.
- R9: Mode codes 6 and 7 give address 0x000000 and a low extra-cycle flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bank_ld_i | input | 1 | Load strobe for the bank register |
| bank_d_i | input | 8 | New bank value |
| page_ld_i | input | 1 | Load strobe for the page-base register |
| page_d_i | input | 16 | New page-base value |
| mode_i | input | 3 | Addressing-mode code (0..5 used) |
| dir_off_i | input | 8 | Direct-window offset |
| abs_op_i | input | 16 | Absolute operand |
| idx_x_i | input | 16 | X index value |
| idx_y_i | input | 16 | Y index value |
| addr_o | output | 24 | Effective address |
| extra_cyc_o | output | 1 | Extra address-generation cycle needed |

## Verification
The direct modes are swept over every offset for six page bases. The bases include a zero low byte, a nonzero low byte, 0xFF00, 0xFF01 and 0xFFFF, so the sweep separates a correct carry into bank 1 from a 16-bit wrap and checks the extra-cycle flag for both low-byte cases. The indexed direct modes use X and Y values that are distinct from each other, so a swapped index select shows up as a mismatch. The absolute modes are tried with bank bytes 0x00, 0x7F and 0xFF against operands and indexes that do and do not carry, which separates carry into the bank byte and wrap at 24 bits from a truncated 16-bit sum. Register loads are checked just before and just after the loading edge, and with the strobe low, to confirm the next-edge timing and the hold behaviour.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [2:0] {
    MODE_DIR   = 3'd0,
    MODE_DIR_X = 3'd1,
    MODE_DIR_Y = 3'd2,
    MODE_ABS   = 3'd3,
    MODE_ABS_X = 3'd4,
    MODE_ABS_Y = 3'd5
  } mode_e;

  typedef struct packed {
    logic dir_fam;
    logic abs_fam;
    logic use_idx;
    logic sel_y;
  } mode_dec_t;

  function automatic mode_dec_t decode_mode(input logic [2:0] m);
    mode_dec_t d;
    d = '0;
    case (m)
      MODE_DIR:   d.dir_fam = 1'b1;
      MODE_DIR_X: begin d.dir_fam = 1'b1; d.use_idx = 1'b1; end
      MODE_DIR_Y: begin d.dir_fam = 1'b1; d.use_idx = 1'b1; d.sel_y = 1'b1; end
      MODE_ABS:   d.abs_fam = 1'b1;
      MODE_ABS_X: begin d.abs_fam = 1'b1; d.use_idx = 1'b1; end
      MODE_ABS_Y: begin d.abs_fam = 1'b1; d.use_idx = 1'b1; d.sel_y = 1'b1; end
      default:    d = '0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/eag_ld_reg.sv
module eag_ld_reg #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_VAL;
    else if (ld_i) q_o <= d_i;
  end
endmodule

// File: rtl/eag_dir_path.sv
module eag_dir_path #(
  parameter int unsigned PAGE_W = 16,
  parameter int unsigned OFF_W  = 8,
  parameter int unsigned IDX_W  = 16,
  parameter int unsigned ADDR_W = 24
) (
  input  logic [PAGE_W-1:0] page_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              use_idx_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              extra_o
);
  logic [ADDR_W-1:0] idx_ext;

  // full-width sum so a high base carries into the next bank
  always_comb begin
    idx_ext = use_idx_i ? ADDR_W'(idx_i) : '0;
    addr_o  = ADDR_W'(page_i) + ADDR_W'(off_i) + idx_ext;
    extra_o = |page_i[OFF_W-1:0];
  end
endmodule

// File: rtl/eag_abs_path.sv
module eag_abs_path #(
  parameter int unsigned BANK_W = 8,
  parameter int unsigned OP_W   = 16,
  parameter int unsigned IDX_W  = 16,
  localparam int unsigned ADDR_W = BANK_W + OP_W
) (
  input  logic [BANK_W-1:0] bank_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              use_idx_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] idx_ext;

  always_comb begin
    idx_ext = use_idx_i ? ADDR_W'(idx_i) : '0;
    addr_o  = {bank_i, op_i} + idx_ext;
  end
endmodule

// File: rtl/bank_addr_gen.sv
module bank_addr_gen
  import eag_pkg::*;
#(
  parameter int unsigned BANK_W = 8,
  parameter int unsigned PAGE_W = 16,
  parameter int unsigned OFF_W  = 8,
  parameter int unsigned IDX_W  = 16,
  localparam int unsigned ADDR_W = BANK_W + PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bank_ld_i,
  input  logic [BANK_W-1:0] bank_d_i,
  input  logic              page_ld_i,
  input  logic [PAGE_W-1:0] page_d_i,
  input  logic [2:0]        mode_i,
  input  logic [OFF_W-1:0]  dir_off_i,
  input  logic [PAGE_W-1:0] abs_op_i,
  input  logic [IDX_W-1:0]  idx_x_i,
  input  logic [IDX_W-1:0]  idx_y_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              extra_cyc_o
);
  logic [BANK_W-1:0] bank_q;
  logic [PAGE_W-1:0] page_q;
  logic [IDX_W-1:0]  idx_sel;
  logic [ADDR_W-1:0] dir_addr, abs_addr;
  logic              dir_extra;
  mode_dec_t         dec;

  eag_ld_reg #(.W(BANK_W), .RST_VAL('0)) u_bank_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(bank_ld_i), .d_i(bank_d_i), .q_o(bank_q)
  );

  eag_ld_reg #(.W(PAGE_W), .RST_VAL('0)) u_page_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(page_ld_i), .d_i(page_d_i), .q_o(page_q)
  );

  always_comb begin
    dec     = decode_mode(mode_i);
    idx_sel = dec.sel_y ? idx_y_i : idx_x_i;
  end

  eag_dir_path #(
    .PAGE_W(PAGE_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
  ) u_dir (
    .page_i(page_q), .off_i(dir_off_i), .idx_i(idx_sel), .use_idx_i(dec.use_idx),
    .addr_o(dir_addr), .extra_o(dir_extra)
  );

  eag_abs_path #(.BANK_W(BANK_W), .OP_W(PAGE_W), .IDX_W(IDX_W)) u_abs (
    .bank_i(bank_q), .op_i(abs_op_i), .idx_i(idx_sel), .use_idx_i(dec.use_idx),
    .addr_o(abs_addr)
  );

  always_comb begin
    addr_o      = '0;
    extra_cyc_o = 1'b0;
    if (dec.dir_fam) begin
      addr_o      = dir_addr;
      extra_cyc_o = dir_extra;
    end else if (dec.abs_fam) begin
      addr_o      = abs_addr;
    end
  end
endmodule

// File: rtl/bank_addr_gen_chk.sv
module bank_addr_gen_chk
  import eag_pkg::*;
#(
  parameter int unsigned BANK_W = 8,
  parameter int unsigned PAGE_W = 16,
  parameter int unsigned OFF_W  = 8,
  localparam int unsigned ADDR_W = BANK_W + PAGE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bank_ld_i,
  input logic [BANK_W-1:0] bank_d_i,
  input logic              page_ld_i,
  input logic [PAGE_W-1:0] page_d_i,
  input logic [2:0]        mode_i,
  input logic [PAGE_W-1:0] abs_op_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              extra_cyc_o,
  input logic [BANK_W-1:0] bank_q,
  input logic [PAGE_W-1:0] page_q
);
  AST_BANK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_ld_i |=> bank_q == $past(bank_d_i)); // R2
  AST_BANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bank_ld_i |=> $stable(bank_q)); // R2
  AST_PAGE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_ld_i |=> page_q == $past(page_d_i)); // R3
  AST_PAGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !page_ld_i |=> $stable(page_q)); // R3
  AST_DIR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_DIR) |-> (addr_o[ADDR_W-1:PAGE_W+1] == '0 && addr_o >= ADDR_W'(page_q))); // R4
  AST_ABS_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_ABS) |-> addr_o == {bank_q, abs_op_i}); // R6
  AST_ZERO_LOW_NO_EXTRA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i <= 3'd2 && page_q[OFF_W-1:0] == '0) |-> !extra_cyc_o); // R8
  AST_ABS_NO_EXTRA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i >= 3'd3) |-> !extra_cyc_o); // R8
  AST_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i >= 3'd6) |-> addr_o == '0); // R9
endmodule

bind bank_addr_gen bank_addr_gen_chk #(
  .BANK_W(BANK_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bank_ld_i(bank_ld_i), .bank_d_i(bank_d_i),
  .page_ld_i(page_ld_i), .page_d_i(page_d_i), .mode_i(mode_i), .abs_op_i(abs_op_i),
  .addr_o(addr_o), .extra_cyc_o(extra_cyc_o), .bank_q(bank_q), .page_q(page_q)
);

// File: tb/bank_addr_gen_tb.sv
`timescale 1ns/1ps
module bank_addr_gen_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bank_ld_i = 1'b0;
  logic [7:0]  bank_d_i = '0;
  logic        page_ld_i = 1'b0;
  logic [15:0] page_d_i = '0;
  logic [2:0]  mode_i = '0;
  logic [7:0]  dir_off_i = '0;
  logic [15:0] abs_op_i = '0;
  logic [15:0] idx_x_i = '0;
  logic [15:0] idx_y_i = '0;
  logic [23:0] addr_o;
  logic        extra_cyc_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  bank_addr_gen u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bank_ld_i(bank_ld_i), .bank_d_i(bank_d_i),
    .page_ld_i(page_ld_i), .page_d_i(page_d_i), .mode_i(mode_i), .dir_off_i(dir_off_i),
    .abs_op_i(abs_op_i), .idx_x_i(idx_x_i), .idx_y_i(idx_y_i),
    .addr_o(addr_o), .extra_cyc_o(extra_cyc_o)
  );

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%06h expected=%06h", tag, act, exp);
    end
  endtask

  task automatic load_bank(input logic [7:0] v);
    @(negedge clk_i);
    bank_ld_i = 1'b1; bank_d_i = v;
    @(negedge clk_i);
    bank_ld_i = 1'b0;
  endtask

  task automatic load_page(input logic [15:0] v);
    @(negedge clk_i);
    page_ld_i = 1'b1; page_d_i = v;
    @(negedge clk_i);
    page_ld_i = 1'b0;
  endtask

  initial begin
    logic [15:0] pages [6] = '{16'h0000, 16'h0100, 16'h12AB, 16'hFF00, 16'hFF01, 16'hFFFF};
    logic [15:0] idxs  [4] = '{16'h0000, 16'h0001, 16'h00FF, 16'hFFFF};
    logic [7:0]  banks [3] = '{8'h00, 8'h7F, 8'hFF};
    logic [15:0] ops   [4] = '{16'h0000, 16'h8000, 16'hFFFF, 16'h1234};
    logic [23:0] exp;

    // R1: reset values, observed during reset
    mode_i = 3'd3; abs_op_i = 16'h1234; bank_d_i = 8'hAA; bank_ld_i = 1'b1;
    #12;
    chk("R1 bank during reset", addr_o, 24'h001234);
    mode_i = 3'd0; dir_off_i = 8'h5A;
    #1 chk("R1 page during reset", addr_o, 24'h00005A);
    chk("R1 flag during reset", {23'd0, extra_cyc_o}, 24'd0);
    bank_ld_i = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    mode_i = 3'd3; #1 chk("R1 bank after reset", addr_o, 24'h001234);

    // R2: bank load timing and hold
    @(negedge clk_i);
    bank_ld_i = 1'b1; bank_d_i = 8'h3C;
    #1 chk("R2 bank before edge", addr_o, 24'h001234);
    @(negedge clk_i);
    bank_ld_i = 1'b0; bank_d_i = 8'hC3;
    #1 chk("R2 bank after edge", addr_o, 24'h3C1234);
    @(negedge clk_i); @(negedge clk_i);
    #1 chk("R2 bank hold", addr_o, 24'h3C1234);

    // R3: page load timing and hold
    mode_i = 3'd0; dir_off_i = 8'h10;
    @(negedge clk_i);
    page_ld_i = 1'b1; page_d_i = 16'h4400;
    #1 chk("R3 page before edge", addr_o, 24'h000010);
    @(negedge clk_i);
    page_ld_i = 1'b0; page_d_i = 16'h9999;
    #1 chk("R3 page after edge", addr_o, 24'h004410);
    @(negedge clk_i); @(negedge clk_i);
    #1 chk("R3 page hold", addr_o, 24'h004410);

    // R4 R5 R8: direct sweeps
    foreach (pages[p]) begin
      load_page(pages[p]);
      for (int off = 0; off < 256; off++) begin
        dir_off_i = 8'(off);
        mode_i = 3'd0; #1;
        exp = {8'h00, pages[p]} + 24'(off);
        chk("R4 direct", addr_o, exp);
        chk("R8 direct flag", {23'd0, extra_cyc_o}, {23'd0, pages[p][7:0] != 8'h00});
        foreach (idxs[i]) begin
          idx_x_i = idxs[i]; idx_y_i = ~idxs[i];
          mode_i = 3'd1; #1;
          chk("R5 direct X", addr_o, {8'h00, pages[p]} + 24'(off) + {8'h00, idxs[i]});
          chk("R8 direct X flag", {23'd0, extra_cyc_o}, {23'd0, pages[p][7:0] != 8'h00});
          mode_i = 3'd2; #1;
          chk("R5 direct Y", addr_o, {8'h00, pages[p]} + 24'(off) + {8'h00, ~idxs[i]});
        end
      end
    end
    load_page(16'hFF01); mode_i = 3'd0; dir_off_i = 8'hFF;
    #1 chk("R4 FF01+FF into bank 1", addr_o, 24'h010000);

    // R6 R7 R8: absolute sweeps
    foreach (banks[b]) begin
      load_bank(banks[b]);
      foreach (ops[o]) begin
        abs_op_i = ops[o];
        mode_i = 3'd3; #1;
        chk("R6 absolute", addr_o, {banks[b], ops[o]});
        chk("R8 absolute flag", {23'd0, extra_cyc_o}, 24'd0);
        foreach (idxs[i]) begin
          idx_x_i = idxs[i]; idx_y_i = 16'h0F0F ^ idxs[i];
          mode_i = 3'd4; #1;
          chk("R7 absolute X", addr_o, {banks[b], ops[o]} + {8'h00, idxs[i]});
          chk("R8 absolute X flag", {23'd0, extra_cyc_o}, 24'd0);
          mode_i = 3'd5; #1;
          chk("R7 absolute Y", addr_o, {banks[b], ops[o]} + {8'h00, 16'h0F0F ^ idxs[i]});
        end
      end
    end
    load_bank(8'h12); abs_op_i = 16'hFFFF; idx_x_i = 16'h0001; mode_i = 3'd4;
    #1 chk("R7 carry into bank", addr_o, 24'h130000);
    load_bank(8'hFF);
    #1 chk("R7 wrap at 24 bits", addr_o, 24'h000000);

    // R9: unused codes
    load_page(16'h12AB);
    for (int m = 6; m < 8; m++) begin
      mode_i = 3'(m); dir_off_i = 8'h77; abs_op_i = 16'hBEEF;
      #1 chk("R9 unused address", addr_o, 24'h000000);
      chk("R9 unused flag", {23'd0, extra_cyc_o}, 24'd0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule